// File: doc/BRIEF.md
# Per-CPU Local Interrupt Controller

This block is the part of a multiprocessor interrupt controller that belongs to one CPU. It owns the CPU's private interrupt identifiers (0 to 31) and picks up the external pending vector that a shared distributor has already routed to this CPU. External line k appears to software as identifier 32+k. The private identifiers include a range (0 to 15) that other CPUs can raise as inter-processor interrupts. A register write sends such interrupts to any set of up to eight CPUs.

Software works through command registers. It enables, disables and completes an interrupt by writing that interrupt's identifier, not a bitmask. It claims the next interrupt by reading a ready register, which returns the identifier. A claimed interrupt is held back until software writes the same identifier to the completion register. For external identifiers, a claim and a completion are each reported to the distributor as a one-cycle pulse that carries the line index. Each private line has its own trigger mode: high level, low level, rising edge or falling edge. The block has no nesting or priority levels. The lowest identifier always wins.

The register frame is 0x1000 bytes, with `reg_addr` as the byte offset inside it. Reads return data one cycle after `reg_rd`.

Top module: `cpu_local_intc`

## Requirements
- R1: Bit 0 of offset 0x000 is the controller enable and resets to 0. While it is clear, `irq` stays low and a read of 0x06C returns 1023 with no side effect.
- R2: Writing identifier i (i < 32) to 0x0A0 enables private line i, and writing it to 0x0A4 disables it. Any value of 32 or above written to either register changes nothing.
- R3: Trigger modes sit at 0x014 (lines 0 to 15) and 0x018 (lines 16 to 31), two bits per line at bit 2*(i mod 16). The codes are 0 high level, 1 low level, 2 rising edge, 3 falling edge. Both words reset to 0 and read back what was written.
- R4: A read of 0x06C returns the lowest-numbered candidate, with private lines 0 to 31 ranked before external identifiers 32+k. It returns 1023 when there is no candidate. `reg_rdata` is valid one cycle after `reg_rd`.
- R5: A claimed identifier is not a candidate again until it is completed. A claim clears that line's latched edge.
- R6: Writing identifier i to 0x0B4 completes it, and a private line that is still pending becomes a candidate again. For an identifier 32+k with k below the external count, `ext_done_vld` pulses with `ext_done_idx` = k one cycle after the write.
- R7: A write to 0x060 with a nonzero mask in bits [15:8] pulses `ipi_out_vld` for one cycle, one cycle after the write. The pulse carries `ipi_out_id` = bits [3:0] and `ipi_out_mask` = bits [15:8]. A zero mask sends nothing.
- R8: A pulse on `ipi_in_set[j]` latches line j pending whatever its trigger mode. The latch stays set until line j is claimed.
- R9: `ext_pend[k]` makes identifier 32+k a candidate unless it is claimed. Claiming it pulses `ext_claim_vld` with `ext_claim_idx` = k one cycle after the read.
- R10: `irq` is high exactly when the controller is enabled and at least one candidate exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset in the CPU frame |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| local_src | input | NUM_LOCAL | Private interrupt source lines |
| ext_pend | input | NUM_EXT | External pending vector from the distributor |
| ext_claim_vld | output | 1 | External claim pulse |
| ext_claim_idx | output | clog2(NUM_EXT) | Claimed external line index |
| ext_done_vld | output | 1 | External completion pulse |
| ext_done_idx | output | clog2(NUM_EXT) | Completed external line index |
| ipi_in_set | input | 16 | Incoming inter-processor interrupt pulses, one per identifier |
| ipi_out_vld | output | 1 | Outgoing inter-processor interrupt pulse |
| ipi_out_id | output | 4 | Outgoing identifier |
| ipi_out_mask | output | NUM_CPU | Destination CPU mask |
| irq | output | 1 | Interrupt request to the core |

## Verification
The bench enables a line with a number of 32 or above whose low five bits match a disabled pending line. A design that cut the identifier down to its low bits would raise `irq` there. It claims two pending lines in a row and then reads once more. A design that did not hold back the claimed line would return the same identifier twice, and one with a wrong empty code would return something other than 1023. Edge lines are pulsed and released before the claim, and an IPI is pulsed into a line set to high-level mode. A design that followed the source level, or that never cleared the latch on a claim, would either miss the interrupt or present it again after completion. External lines are checked against a pending private line and around claim and completion. This catches a priority order that is backwards and an index that is off by the base of 32.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int          ID_W     = 10;
  localparam logic [9:0]  NONE_ID  = 10'd1023;
  localparam int          EXT_BASE = 32;
  localparam int          IPI_IDS  = 16;

  localparam logic [11:0] OFF_CTRL   = 12'h000;
  localparam logic [11:0] OFF_TRIG0  = 12'h014;
  localparam logic [11:0] OFF_IPI    = 12'h060;
  localparam logic [11:0] OFF_CLAIM  = 12'h06C;
  localparam logic [11:0] OFF_EN_SET = 12'h0A0;
  localparam logic [11:0] OFF_EN_CLR = 12'h0A4;
  localparam logic [11:0] OFF_DONE   = 12'h0B4;

  typedef enum logic [1:0] {
    TRG_LVL_HI = 2'd0,
    TRG_LVL_LO = 2'd1,
    TRG_RISE   = 2'd2,
    TRG_FALL   = 2'd3
  } trig_e;
endpackage

// File: rtl/lic_regs.sv
module lic_regs
  import lic_pkg::*;
#(
  parameter int NUM_LOCAL = 32,
  parameter int NUM_CPU   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [11:0]            addr,
  input  logic [31:0]            wdata,
  output logic                   ctrl_en,
  output logic [2*NUM_LOCAL-1:0] trig,
  output logic [NUM_LOCAL-1:0]   en,
  output logic [31:0]            cfg_rdata,
  output logic                   done_vld,
  output logic [ID_W-1:0]        done_id,
  output logic                   ipi_vld,
  output logic [3:0]             ipi_id,
  output logic [NUM_CPU-1:0]     ipi_mask
);
  localparam int IDX_W = $clog2(NUM_LOCAL);
  localparam int TW    = (2*NUM_LOCAL + 31) / 32;

  logic               ctrl_q, ctrl_d;
  logic [TW*32-1:0]   trig_q, trig_d;
  logic [NUM_LOCAL-1:0] en_q, en_d;
  logic               id_local;

  assign id_local = (wdata < 32'(NUM_LOCAL));

  always_comb begin
    ctrl_d = ctrl_q;
    en_d   = en_q;
    trig_d = trig_q;
    if (wr) begin
      if (addr == OFF_CTRL) ctrl_d = wdata[0];
      if (addr == OFF_EN_SET && id_local) en_d[wdata[IDX_W-1:0]] = 1'b1;
      if (addr == OFF_EN_CLR && id_local) en_d[wdata[IDX_W-1:0]] = 1'b0;
      for (int w = 0; w < TW; w++) begin
        if (addr == OFF_TRIG0 + 12'(4*w)) trig_d[w*32 +: 32] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      en_q   <= '0;
      trig_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      en_q   <= en_d;
      trig_q <= trig_d;
    end
  end

  always_comb begin
    cfg_rdata = 32'd0;
    if (addr == OFF_CTRL) cfg_rdata = {31'd0, ctrl_q};
    for (int w = 0; w < TW; w++) begin
      if (addr == OFF_TRIG0 + 12'(4*w)) cfg_rdata = trig_q[w*32 +: 32];
    end
  end

  assign ctrl_en  = ctrl_q;
  assign en       = en_q;
  assign trig     = trig_q[2*NUM_LOCAL-1:0];
  assign done_vld = wr && (addr == OFF_DONE);
  assign done_id  = wdata[ID_W-1:0];
  assign ipi_mask = wdata[8 +: NUM_CPU];
  assign ipi_id   = wdata[3:0];
  assign ipi_vld  = wr && (addr == OFF_IPI) && (|wdata[8 +: NUM_CPU]);

  // R2: out-of-range identifiers leave the enable vector untouched
  a_r2_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == OFF_EN_SET || addr == OFF_EN_CLR) && !id_local) |=> $stable(en_q));
endmodule

// File: rtl/lic_src.sv
module lic_src
  import lic_pkg::*;
#(
  parameter int NUM_LOCAL = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_LOCAL-1:0]         src,
  input  logic [2*NUM_LOCAL-1:0]       trig,
  input  logic [NUM_LOCAL-1:0]         en,
  input  logic [IPI_IDS-1:0]           ipi_set,
  input  logic                         claim_vld,
  input  logic [$clog2(NUM_LOCAL)-1:0] claim_idx,
  input  logic                         done_vld,
  input  logic [$clog2(NUM_LOCAL)-1:0] done_idx,
  output logic [NUM_LOCAL-1:0]         cand
);
  logic [NUM_LOCAL-1:0] src_q, latch_q, latch_d, active_q, active_d, lvl, edg, ipi_hit;

  for (genvar i = 0; i < NUM_LOCAL; i++) begin : g_line
    trig_e mode;
    assign mode = trig_e'(trig[2*i +: 2]);
    assign lvl[i] = (mode == TRG_LVL_HI) ? src[i] :
                    (mode == TRG_LVL_LO) ? ~src[i] : 1'b0;
    assign edg[i] = (mode == TRG_RISE) ? (src[i] & ~src_q[i]) :
                    (mode == TRG_FALL) ? (~src[i] & src_q[i]) : 1'b0;
    if (i < IPI_IDS) begin : g_ipi
      assign ipi_hit[i] = ipi_set[i];
    end else begin : g_noipi
      assign ipi_hit[i] = 1'b0;
    end
    // clear on claim first, a new event in the same cycle wins
    assign latch_d[i] = (edg[i] | ipi_hit[i]) ? 1'b1 :
                        (claim_vld && claim_idx == i) ? 1'b0 : latch_q[i];
    assign active_d[i] = (claim_vld && claim_idx == i) ? 1'b1 :
                         (done_vld && done_idx == i) ? 1'b0 : active_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= '0;
      latch_q  <= '0;
      active_q <= '0;
    end else begin
      src_q    <= src;
      latch_q  <= latch_d;
      active_q <= active_d;
    end
  end

  assign cand = (lvl | latch_q) & en & ~active_q;

  // R5: a line is never claimed twice without a completion in between
  a_r5_no_double_claim: assert property (@(posedge clk) disable iff (!rst_n)
    claim_vld |-> !active_q[claim_idx]);
  // R5: after a claim the line stays withheld
  a_r5_claim_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_vld && !done_vld) |=> !cand[$past(claim_idx)]);
  // R6: completion releases the active flag
  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && !claim_vld) |=> !active_q[$past(done_idx)]);
endmodule

// File: rtl/lic_arb.sv
module lic_arb #(
  parameter int N = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  output logic                 found,
  output logic [$clog2(N)-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = ($clog2(N))'(i);
      end
    end
  end

  // R4: the chosen index is a live request
  a_r4_pick_valid: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req[idx]);
  a_r4_none_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (req == '0));
endmodule

// File: rtl/cpu_local_intc.sv
module cpu_local_intc
  import lic_pkg::*;
#(
  parameter int NUM_LOCAL = 32,
  parameter int NUM_EXT   = 32,
  parameter int NUM_CPU   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [11:0]                reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_LOCAL-1:0]       local_src,
  input  logic [NUM_EXT-1:0]         ext_pend,
  output logic                       ext_claim_vld,
  output logic [$clog2(NUM_EXT)-1:0] ext_claim_idx,
  output logic                       ext_done_vld,
  output logic [$clog2(NUM_EXT)-1:0] ext_done_idx,
  input  logic [IPI_IDS-1:0]         ipi_in_set,
  output logic                       ipi_out_vld,
  output logic [3:0]                 ipi_out_id,
  output logic [NUM_CPU-1:0]         ipi_out_mask,
  output logic                       irq
);
  localparam int IDX_W = $clog2(NUM_LOCAL);
  localparam int EXT_W = $clog2(NUM_EXT);
  localparam int N     = NUM_LOCAL + NUM_EXT;
  localparam int AW    = $clog2(N);

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  logic                   ctrl_en, done_vld, ipi_vld;
  logic [2*NUM_LOCAL-1:0] trig;
  logic [NUM_LOCAL-1:0]   en, loc_cand;
  logic [31:0]            cfg_rdata;
  logic [ID_W-1:0]        done_id;
  logic [3:0]             ipi_id;
  logic [NUM_CPU-1:0]     ipi_mask;

  lic_regs #(.NUM_LOCAL(NUM_LOCAL), .NUM_CPU(NUM_CPU)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_en(ctrl_en), .trig(trig), .en(en), .cfg_rdata(cfg_rdata),
    .done_vld(done_vld), .done_id(done_id),
    .ipi_vld(ipi_vld), .ipi_id(ipi_id), .ipi_mask(ipi_mask)
  );

  // claim decode
  logic          claim_rd, claim_go, claim_loc, claim_ext, found;
  logic [AW-1:0] win, eoff;
  logic [ID_W-1:0] win_id;
  logic [NUM_EXT-1:0] ext_act_q, ext_act_d, ext_cand;

  assign claim_rd  = reg_rd && (reg_addr == OFF_CLAIM);
  assign claim_go  = claim_rd && ctrl_en && found;
  assign claim_loc = claim_go && (win < AW'(NUM_LOCAL));
  assign claim_ext = claim_go && !(win < AW'(NUM_LOCAL));
  assign eoff      = win - AW'(NUM_LOCAL);
  assign win_id    = (win < AW'(NUM_LOCAL)) ? ID_W'(win)
                                            : ID_W'(EXT_BASE) + ID_W'(eoff);

  // completion decode
  logic            done_loc, done_ext;
  logic [ID_W-1:0] doff;
  assign doff     = done_id - ID_W'(EXT_BASE);
  assign done_loc = done_vld && (done_id < ID_W'(NUM_LOCAL));
  assign done_ext = done_vld && (done_id >= ID_W'(EXT_BASE)) && (doff < ID_W'(NUM_EXT));

  lic_src #(.NUM_LOCAL(NUM_LOCAL)) u_src (
    .clk(clk), .rst_n(rst_ni), .src(local_src), .trig(trig), .en(en),
    .ipi_set(ipi_in_set),
    .claim_vld(claim_loc), .claim_idx(win[IDX_W-1:0]),
    .done_vld(done_loc), .done_idx(done_id[IDX_W-1:0]),
    .cand(loc_cand)
  );

  assign ext_cand = ext_pend & ~ext_act_q;

  lic_arb #(.N(N)) u_arb (
    .clk(clk), .rst_n(rst_ni), .req({ext_cand, loc_cand}),
    .found(found), .idx(win)
  );

  always_comb begin
    ext_act_d = ext_act_q;
    if (done_ext)  ext_act_d[doff[EXT_W-1:0]] = 1'b0;
    if (claim_ext) ext_act_d[eoff[EXT_W-1:0]] = 1'b1;
  end

  // output and state registers
  logic [31:0]        rdata_q, rdata_d;
  logic               xc_vld_q, xd_vld_q, io_vld_q;
  logic [EXT_W-1:0]   xc_idx_q, xd_idx_q;
  logic [3:0]         io_id_q;
  logic [NUM_CPU-1:0] io_mask_q;

  always_comb begin
    rdata_d = cfg_rdata;
    if (claim_rd) rdata_d = {22'd0, claim_go ? win_id : NONE_ID};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_act_q <= '0;
      rdata_q   <= '0;
      xc_vld_q  <= 1'b0;
      xc_idx_q  <= '0;
      xd_vld_q  <= 1'b0;
      xd_idx_q  <= '0;
      io_vld_q  <= 1'b0;
      io_id_q   <= '0;
      io_mask_q <= '0;
    end else begin
      ext_act_q <= ext_act_d;
      if (reg_rd) rdata_q <= rdata_d;
      xc_vld_q <= claim_ext;
      if (claim_ext) xc_idx_q <= eoff[EXT_W-1:0];
      xd_vld_q <= done_ext;
      if (done_ext) xd_idx_q <= doff[EXT_W-1:0];
      io_vld_q <= ipi_vld;
      if (ipi_vld) begin
        io_id_q   <= ipi_id;
        io_mask_q <= ipi_mask;
      end
    end
  end

  assign reg_rdata     = rdata_q;
  assign ext_claim_vld = xc_vld_q;
  assign ext_claim_idx = xc_idx_q;
  assign ext_done_vld  = xd_vld_q;
  assign ext_done_idx  = xd_idx_q;
  assign ipi_out_vld   = io_vld_q;
  assign ipi_out_id    = io_id_q;
  assign ipi_out_mask  = io_mask_q;
  assign irq           = ctrl_en && found;

  // R9: an external claim targets a pending, in-range line
  a_r9_ext_claim_pending: assert property (@(posedge clk) disable iff (!rst_ni)
    claim_ext |-> (eoff < AW'(NUM_EXT)) && ext_pend[eoff[EXT_W-1:0]]);
  // R4: an empty or disabled claim read answers 1023
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_ni)
    (claim_rd && !claim_go) |=> (reg_rdata == 32'd1023));
  // R7: an outgoing IPI never carries an empty mask
  a_r7_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_ni)
    ipi_out_vld |-> (ipi_out_mask != '0));
  // R1: no claim side effect while disabled
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    (claim_rd && !ctrl_en) |=> !ext_claim_vld);
endmodule

// File: tb/sim_cpu_local_intc.sv
`timescale 1ns/1ps
module sim_cpu_local_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] local_src = '0;
  logic [31:0] ext_pend = '0;
  logic        ext_claim_vld, ext_done_vld, ipi_out_vld, irq;
  logic [4:0]  ext_claim_idx, ext_done_idx;
  logic [15:0] ipi_in_set = '0;
  logic [3:0]  ipi_out_id;
  logic [7:0]  ipi_out_mask;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;
  logic        cv;
  logic [4:0]  ci;

  always #4 clk = ~clk;

  cpu_local_intc u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .local_src(local_src), .ext_pend(ext_pend),
    .ext_claim_vld(ext_claim_vld), .ext_claim_idx(ext_claim_idx),
    .ext_done_vld(ext_done_vld), .ext_done_idx(ext_done_idx),
    .ipi_in_set(ipi_in_set), .ipi_out_vld(ipi_out_vld),
    .ipi_out_id(ipi_out_id), .ipi_out_mask(ipi_out_mask), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    rv = reg_rdata; cv = ext_claim_vld; ci = ext_claim_idx;
  endtask

  task automatic t_reset;
    check("R1 irq after reset", {31'd0, irq}, 0);
    rd(12'h000);
    check("R1 ctrl reset", rv, 0);
    rd(12'h014);
    check("R3 trig reset", rv, 0);
    rd(12'h06C);
    check("R4 empty claim", rv, 1023);
  endtask

  task automatic t_enable;
    local_src[5] = 1'b1;
    wr(12'h0A0, 5);
    check("R1 disabled irq", {31'd0, irq}, 0);
    rd(12'h06C);
    check("R1 disabled claim", rv, 1023);
    wr(12'h000, 1);
    check("R10 irq with enabled line", {31'd0, irq}, 1);
    wr(12'h0A4, 5);
    check("R2 disable drops irq", {31'd0, irq}, 0);
    local_src[8] = 1'b1;
    wr(12'h0A0, 40);
    check("R2 id 40 ignored", {31'd0, irq}, 0);
    rd(12'h06C);
    check("R2 id 40 claim", rv, 1023);
    local_src[5] = 1'b0; local_src[8] = 1'b0;
  endtask

  task automatic t_claim;
    local_src[2] = 1'b1; local_src[9] = 1'b1;
    wr(12'h0A0, 9); wr(12'h0A0, 2);
    rd(12'h06C); check("R4 lowest first", rv, 2);
    check("R10 second still pending", {31'd0, irq}, 1);
    rd(12'h06C); check("R5 next is 9", rv, 9);
    check("R5 both claimed irq low", {31'd0, irq}, 0);
    rd(12'h06C); check("R5 nothing left", rv, 1023);
    wr(12'h0B4, 2);
    rd(12'h06C); check("R6 level line returns", rv, 2);
    wr(12'h0B4, 2); wr(12'h0B4, 9);
    wr(12'h0A4, 2); wr(12'h0A4, 9);
    local_src[2] = 1'b0; local_src[9] = 1'b0;
  endtask

  task automatic t_trig;
    local_src[6] = 1'b1;
    wr(12'h014, (32'd2 << 8) | (32'd3 << 12));
    rd(12'h014); check("R3 readback", rv, (32'd2 << 8) | (32'd3 << 12));
    wr(12'h0A0, 4); wr(12'h0A0, 6);
    check("R3 edges idle", {31'd0, irq}, 0);
    @(negedge clk); local_src[4] = 1'b1; local_src[6] = 1'b0;
    @(negedge clk); local_src[4] = 1'b0;
    rd(12'h06C); check("R3 rising latched", rv, 4);
    rd(12'h06C); check("R3 falling latched", rv, 6);
    wr(12'h0B4, 4); wr(12'h0B4, 6);
    rd(12'h06C); check("R5 edge latch cleared", rv, 1023);
    wr(12'h018, 32'd1 << 2);
    wr(12'h0A0, 17);
    check("R3 low level id 17", {31'd0, irq}, 1);
    local_src[17] = 1'b1;
    @(negedge clk);
    check("R3 low level released", {31'd0, irq}, 0);
    wr(12'h0A4, 4); wr(12'h0A4, 6); wr(12'h0A4, 17);
    wr(12'h014, 0); wr(12'h018, 0);
    local_src = '0;
  endtask

  task automatic t_ipi;
    wr(12'h060, (32'hA5 << 8) | 7);
    check("R7 ipi pulse", {31'd0, ipi_out_vld}, 1);
    check("R7 ipi mask", {24'd0, ipi_out_mask}, 32'hA5);
    check("R7 ipi id", {28'd0, ipi_out_id}, 7);
    wr(12'h060, 32'h0000_0003);
    check("R7 zero mask silent", {31'd0, ipi_out_vld}, 0);
    wr(12'h0A0, 1);
    @(negedge clk); ipi_in_set[1] = 1'b1;
    @(negedge clk); ipi_in_set[1] = 1'b0;
    check("R8 ipi raises irq", {31'd0, irq}, 1);
    rd(12'h06C); check("R8 ipi claimed", rv, 1);
    wr(12'h0B4, 1);
    rd(12'h06C); check("R8 ipi latch cleared", rv, 1023);
    wr(12'h0A4, 1);
  endtask

  task automatic t_ext;
    ext_pend[3] = 1'b1;
    local_src[10] = 1'b1;
    wr(12'h0A0, 10);
    rd(12'h06C); check("R4 local before external", rv, 10);
    check("R9 no ext claim for local", {31'd0, cv}, 0);
    rd(12'h06C); check("R9 external id", rv, 35);
    check("R9 claim pulse", {31'd0, cv}, 1);
    check("R9 claim index", {27'd0, ci}, 3);
    rd(12'h06C); check("R5 external withheld", rv, 1023);
    wr(12'h0B4, 35);
    check("R6 done pulse", {31'd0, ext_done_vld}, 1);
    check("R6 done index", {27'd0, ext_done_idx}, 3);
    rd(12'h06C); check("R6 external back", rv, 35);
    wr(12'h0B4, 35); wr(12'h0B4, 10);
    ext_pend = '0; local_src = '0;
    wr(12'h0A4, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_enable();
    t_claim();
    t_trig();
    t_ipi();
    t_ext();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule